// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit sequencer of an Ethernet controller. When software kicks it, it walks a ring of 8-byte buffer descriptors in memory. For every descriptor marked ready it fetches the buffer one byte at a time over a simple request/acknowledge memory port and streams the bytes to a frame output with a valid/ready handshake. It then clears the descriptor's ready flag, writes the descriptor back and moves on to the next one. A frame may span several buffers; the buffer flagged last closes it.

The walk ends at the first descriptor that is not ready, or after a fixed number of descriptors in one kick. Frames longer than the frame limit are cut short. Single-cycle event pulses report each finished buffer, each finished frame and each truncation. A register write sets the ring base and moves the current pointer back to it. A level input carries the controller's control word, and its enable bit gates the kick.

Top module: `tx_ring_walker`

## Requirements
- R1: Memory is 32 bits wide and big-endian: byte address a sits in bits [31-8*(a mod 4) -: 8] of the word at a with its low 2 bits cleared. A descriptor holds flags in bits 31:16 and length in bits 15:0 of its first word, and the buffer address in its second word at descriptor+4. A memory request holds its address and direction until acknowledged.
- R2: A kick starts a walk only when bit 1 of ctrl_word is 1 and the walker is idle. Otherwise it causes no memory access and changes nothing.
- R3: The walk stops at the first descriptor whose flag bit 15 (ready) is 0. That descriptor is neither streamed nor written back, and it raises no event.
- R4: Buffer bytes leave in ascending address order, one per out_valid/out_ready handshake. Data and last stay stable while out_ready is low.
- R5: On a descriptor with flag bit 11 (last), out_last marks its final byte and ev_txf pulses. The next buffer starts a new frame. A last buffer whose effective length is 0 emits no byte but still ends the frame.
- R6: If the bytes of a frame so far plus a buffer's length would exceed MAX_FRAME (default 2032), only the bytes up to MAX_FRAME are sent and ev_babt pulses once for that descriptor.
- R7: After each processed descriptor, the first word is written back to the same address with flag bit 15 cleared and the other flags and the original length unchanged, and ev_txb pulses.
- R8: The next descriptor address is the ring base when flag bit 13 (wrap) is set, and the current address plus 8 otherwise.
- R9: A single kick processes at most MAX_DESC descriptors (default 1024). A later kick resumes at the following descriptor.
- R10: A ring base write stores the value with its low 2 bits cleared and sets the current descriptor pointer to it.
- R11: busy is 0 after reset. It is 1 from an accepted kick until the walk stops, and out_valid is never 1 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Controller control word; bit 1 enables transmit |
| kick | input | 1 | Transmit start pulse |
| base_wr | input | 1 | Ring base register write strobe |
| base_wdata | input | AW | Ring base write value |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address (byte addressed, low 2 bits 0) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Frame sink ready |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of a frame |
| ev_txb | output | 1 | Buffer done pulse |
| ev_txf | output | 1 | Frame done pulse |
| ev_babt | output | 1 | Frame truncation pulse |

## Verification
Streamed bytes and their last markers are due on the handshake edge. The bench captures them at that edge, and a randomly stalled ready exercises the hold rule. Event pulses come one cycle after the acknowledge that completes a descriptor read or write-back. Descriptor write-backs reach memory on the acknowledge edge. The bench therefore waits for busy to fall and then a few more cycles before it compares byte lists, event counts and memory words. A rejected kick is judged after ten idle cycles, by the count of memory acknowledges and by busy.

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int MAX_DESC  = 1024,
  parameter int MAX_FRAME = 2032,
  parameter int AW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   ctrl_word,
  input  logic          kick,
  input  logic          base_wr,
  input  logic [AW-1:0] base_wdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          ev_txb,
  output logic          ev_txf,
  output logic          ev_babt
);
  localparam int FW = $clog2(MAX_FRAME + 1);
  localparam int CW = $clog2(MAX_DESC + 1);

  typedef enum logic [2:0] {IDLE, RD_HEAD, RD_PTR, RD_BYTE, SEND, WR_BACK} st_t;

  st_t           st;
  logic [AW-1:0] base, cur, bptr;
  logic [15:0]   flags, len;
  logic [FW-1:0] left, fsize, room, eff;
  logic [CW-1:0] ndesc;
  logic [7:0]    byte_q, lane;
  logic          cut, hs;

  assign room = FW'(MAX_FRAME) - fsize;
  assign cut  = 32'(mem_rdata[15:0]) > 32'(room);
  assign eff  = cut ? room : FW'(mem_rdata[15:0]);
  assign hs   = out_valid && out_ready;

  always_comb begin
    case (bptr[1:0])
      2'd0:    lane = mem_rdata[31:24];
      2'd1:    lane = mem_rdata[23:16];
      2'd2:    lane = mem_rdata[15:8];
      default: lane = mem_rdata[7:0];
    endcase
  end

  assign busy      = st != IDLE;
  assign mem_req   = st == RD_HEAD || st == RD_PTR || st == RD_BYTE || st == WR_BACK;
  assign mem_we    = st == WR_BACK;
  assign mem_wdata = {flags & 16'h7FFF, len};
  assign out_valid = st == SEND;
  assign out_data  = byte_q;
  assign out_last  = flags[11] && left == FW'(1);

  always_comb begin
    case (st)
      RD_PTR:  mem_addr = cur + AW'(4);
      RD_BYTE: mem_addr = {bptr[AW-1:2], 2'b00};
      default: mem_addr = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      base <= '0;
      cur <= '0;
      bptr <= '0;
      flags <= '0;
      len <= '0;
      left <= '0;
      fsize <= '0;
      ndesc <= '0;
      byte_q <= '0;
      ev_txb <= 1'b0;
      ev_txf <= 1'b0;
      ev_babt <= 1'b0;
    end else begin
      ev_txb <= 1'b0;
      ev_txf <= 1'b0;
      ev_babt <= 1'b0;
      case (st)
        IDLE: if (kick && ctrl_word[1]) begin
          st <= RD_HEAD;
          ndesc <= '0;
          fsize <= '0;
        end
        RD_HEAD: if (mem_ack) begin
          if (!mem_rdata[31]) st <= IDLE;
          else begin
            flags <= mem_rdata[31:16];
            len <= mem_rdata[15:0];
            left <= eff;
            ev_babt <= cut;
            st <= RD_PTR;
          end
        end
        RD_PTR: if (mem_ack) begin
          bptr <= mem_rdata[AW-1:0];
          st <= (left == '0) ? WR_BACK : RD_BYTE;
        end
        RD_BYTE: if (mem_ack) begin
          byte_q <= lane;
          st <= SEND;
        end
        SEND: if (hs) begin
          bptr <= bptr + AW'(1);
          left <= left - FW'(1);
          fsize <= fsize + FW'(1);
          st <= (left == FW'(1)) ? WR_BACK : RD_BYTE;
        end
        WR_BACK: if (mem_ack) begin
          ev_txb <= 1'b1;
          if (flags[11]) begin
            ev_txf <= 1'b1;
            fsize <= '0;
          end
          cur <= flags[13] ? base : cur + AW'(8);
          ndesc <= ndesc + CW'(1);
          st <= (ndesc == CW'(MAX_DESC - 1)) ? IDLE : RD_HEAD;
        end
        default: st <= IDLE;
      endcase
      if (base_wr) begin
        base <= {base_wdata[AW-1:2], 2'b00};
        cur <= {base_wdata[AW-1:2], 2'b00};
      end
    end
  end
endmodule

// File: rtl/tx_ring_walker_chk.sv
module tx_ring_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   ctrl_word,
  input logic          kick,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic          ev_txb,
  input logic          ev_txf,
  input logic          ev_babt
);
  assert_mem_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_kick_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && kick && !ctrl_word[1] |=> !busy);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_frame_with_buf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txf |-> ev_txb);

  assert_babble_in_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_babt |-> busy);

  assert_wb_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr[1:0] == 2'b00);

  assert_stream_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
endmodule

bind tx_ring_walker tx_ring_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .kick(kick), .busy(busy),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babt(ev_babt)
);

// File: tb/tb_tx_ring_walker.sv
module tb_tx_ring_walker;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ctrl_word = 32'h0;
  logic kick = 1'b0, base_wr = 1'b0;
  logic [AW-1:0] base_wdata = '0;
  logic busy, mem_req, mem_we, mem_ack, out_valid, out_ready, out_last;
  logic ev_txb, ev_txf, ev_babt;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  tx_ring_walker #(.MAX_DESC(6), .MAX_FRAME(40), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .kick(kick),
    .base_wr(base_wr), .base_wdata(base_wdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babt(ev_babt)
  );

  logic [31:0] mem [0:255];
  logic ack_q = 1'b0;
  logic [31:0] rdata_q = '0;
  assign mem_ack = ack_q;
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    ack_q <= mem_req && !ack_q;
    if (mem_req && !ack_q) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else rdata_q <= mem[mem_addr[9:2]];
    end
  end

  logic [7:0] cap_data [0:127];
  logic       cap_last [0:127];
  int cap_n = 0, n_txb = 0, n_txf = 0, n_babt = 0, n_acc = 0;
  always @(posedge clk) begin
    if (out_valid && out_ready) begin
      cap_data[cap_n] <= out_data;
      cap_last[cap_n] <= out_last;
      cap_n <= cap_n + 1;
    end
    if (ev_txb) n_txb <= n_txb + 1;
    if (ev_txf) n_txf <= n_txf + 1;
    if (ev_babt) n_babt <= n_babt + 1;
    if (mem_ack) n_acc <= n_acc + 1;
  end

  logic stall = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic rdy_q = 1'b1;
  assign out_ready = rdy_q;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy_q <= stall ? lfsr[0] : 1'b1;
  end

  int errors = 0, checks = 0;

  function automatic logic [7:0] pat(int a);
    return 8'(a * 7 + 3) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] ln, input int p);
    mem[a >> 2] = {fl, ln};
    mem[(a >> 2) + 1] = p;
  endtask

  task automatic set_base(input logic [AW-1:0] v);
    @(negedge clk); base_wr = 1'b1; base_wdata = v;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_bytes(input int n0, input int a, input int cnt, input bit last_end, input string req);
    for (int k = 0; k < cnt; k++) begin
      check(cap_data[n0 + k] == pat(a + k), req, cap_data[n0 + k], pat(a + k));
      check(cap_last[n0 + k] == (last_end && k == cnt - 1), "R5 last marker", cap_last[n0 + k], last_end && k == cnt - 1);
    end
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R11 busy after reset", busy, 0);
    check(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
    check(mem_req == 1'b0, "R2 no request after reset", mem_req, 0);
  endtask

  task automatic t_disabled();
    int a0;
    set_base(32'h103);
    put_desc(32'h100, 16'h8000, 16'd3, 32'h201);
    put_desc(32'h108, 16'h8800, 16'd2, 32'h300);
    put_desc(32'h110, 16'h0000, 16'd9, 32'h200);
    ctrl_word = 32'hFFFF_FFFD;
    a0 = n_acc;
    pulse_kick();
    repeat (10) @(negedge clk);
    check(n_acc == a0, "R2 disabled kick memory accesses", n_acc - a0, 0);
    check(busy == 1'b0, "R2 disabled kick busy", busy, 0);
    check(mem[32'h40] == 32'h8000_0003, "R2 descriptor untouched", mem[32'h40], 32'h8000_0003);
  endtask

  task automatic t_basic();
    int n0, b0, f0, x0;
    ctrl_word = 32'h0000_0002;
    stall = 1'b1;
    n0 = cap_n; b0 = n_txb; f0 = n_txf; x0 = n_babt;
    pulse_kick();
    check(busy == 1'b1, "R11 busy after accepted kick", busy, 1);
    wait_idle();
    check(cap_n - n0 == 5, "R4 byte count", cap_n - n0, 5);
    check_bytes(n0, 32'h201, 3, 1'b0, "R1 R4 buffer 0 bytes");
    check_bytes(n0 + 3, 32'h300, 2, 1'b1, "R4 buffer 1 bytes");
    check(n_txb - b0 == 2, "R7 buffer events", n_txb - b0, 2);
    check(n_txf - f0 == 1, "R5 frame events", n_txf - f0, 1);
    check(n_babt == x0, "R6 no babble", n_babt - x0, 0);
    check(mem[32'h40] == 32'h0000_0003, "R7 write-back D0", mem[32'h40], 32'h0000_0003);
    check(mem[32'h42] == 32'h0800_0002, "R7 write-back D1", mem[32'h42], 32'h0800_0002);
    check(mem[32'h44] == 32'h0000_0009, "R3 stop descriptor untouched", mem[32'h44], 32'h0000_0009);
    check(mem[32'h45] == 32'h200, "R3 stop descriptor pointer", mem[32'h45], 32'h200);
    stall = 1'b0;
  endtask

  task automatic t_wrap();
    int n0, f0;
    set_base(32'h100);
    put_desc(32'h100, 16'h8800, 16'd1, 32'h320);
    put_desc(32'h108, 16'hA800, 16'd1, 32'h330);
    n0 = cap_n; f0 = n_txf;
    pulse_kick();
    wait_idle();
    check(cap_n - n0 == 2, "R8 wrap walk byte count", cap_n - n0, 2);
    check_bytes(n0, 32'h320, 1, 1'b1, "R8 first");
    check_bytes(n0 + 1, 32'h330, 1, 1'b1, "R8 second");
    check(n_txf - f0 == 2, "R5 one-byte frames", n_txf - f0, 2);
    check(mem[32'h42] == 32'h2800_0001, "R7 R8 wrap flags kept", mem[32'h42], 32'h2800_0001);
    put_desc(32'h100, 16'h8800, 16'd1, 32'h340);
    n0 = cap_n;
    pulse_kick();
    wait_idle();
    check(cap_n - n0 == 1, "R8 pointer returned to base", cap_n - n0, 1);
    check_bytes(n0, 32'h340, 1, 1'b1, "R8 rearmed");
  endtask

  task automatic t_trunc();
    int n0, b0, f0, x0;
    set_base(32'h100);
    put_desc(32'h100, 16'h8000, 16'd30, 32'h200);
    put_desc(32'h108, 16'h8800, 16'd20, 32'h240);
    put_desc(32'h110, 16'h8800, 16'd5, 32'h280);
    put_desc(32'h118, 16'h0000, 16'd0, 32'h0);
    stall = 1'b1;
    n0 = cap_n; b0 = n_txb; f0 = n_txf; x0 = n_babt;
    pulse_kick();
    wait_idle();
    check(cap_n - n0 == 45, "R6 truncated byte count", cap_n - n0, 45);
    check_bytes(n0, 32'h200, 30, 1'b0, "R6 first buffer");
    check_bytes(n0 + 30, 32'h240, 10, 1'b1, "R6 cut buffer");
    check_bytes(n0 + 40, 32'h280, 5, 1'b1, "R5 new frame after cut");
    check(n_babt - x0 == 1, "R6 babble events", n_babt - x0, 1);
    check(n_txb - b0 == 3, "R7 buffer events", n_txb - b0, 3);
    check(n_txf - f0 == 2, "R5 frame events", n_txf - f0, 2);
    check(mem[32'h42] == 32'h0800_0014, "R7 original length kept", mem[32'h42], 32'h0800_0014);
    stall = 1'b0;
  endtask

  task automatic t_cap();
    int n0, b0;
    set_base(32'h100);
    for (int i = 0; i < 8; i++) put_desc(32'h100 + 8 * i, 16'h8800, 16'd1, 32'h380 + i);
    put_desc(32'h140, 16'h0000, 16'd0, 32'h0);
    n0 = cap_n; b0 = n_txb;
    pulse_kick();
    repeat (4) @(negedge clk);
    pulse_kick();
    wait_idle();
    check(cap_n - n0 == 6, "R9 cap per kick (busy kick ignored R2)", cap_n - n0, 6);
    check(n_txb - b0 == 6, "R9 buffer events at cap", n_txb - b0, 6);
    check(mem[32'h4C] == 32'h8800_0001, "R9 descriptor past cap untouched", mem[32'h4C], 32'h8800_0001);
    check_bytes(n0, 32'h380, 1, 1'b1, "R9 first");
    n0 = cap_n;
    pulse_kick();
    wait_idle();
    check(cap_n - n0 == 2, "R9 resume count", cap_n - n0, 2);
    check_bytes(n0, 32'h386, 1, 1'b1, "R9 resume first");
    check_bytes(n0 + 1, 32'h387, 1, 1'b1, "R9 resume second");
    check(mem[32'h4E] == 32'h0800_0001, "R7 last cleared", mem[32'h4E], 32'h0800_0001);
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {pat(4 * i), pat(4 * i + 1), pat(4 * i + 2), pat(4 * i + 3)};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_wrap();
    t_trunc();
    t_cap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule